// File: doc/BRIEF.md
# Job Completion Watchdog

This block watches a set of job ports, one per microcontroller queue, and raises an alarm when a job takes too long. A job is considered issued on a one-cycle start pulse and finished on a one-cycle done pulse. Between the two, a per-port timer counts millisecond ticks through a divide-by-sixteen prescaler. When the timer reaches the programmed limit, the port's request bit is set. Software masks the request bits with per-port enable bits, and a single interrupt line is driven high while any enabled request is pending. A shared counter totals the done pulses from all ports.

Each port runs its own small state machine with three named states. ST_IDLE means no job is being timed. ST_RUN means a job is being timed. ST_FROZEN means the timer expired with freeze selected and is holding. The transitions are as follows. START (ST_IDLE to ST_RUN) happens on a start pulse while the port is enabled. RESTART (ST_RUN or ST_FROZEN to ST_RUN) happens on a start pulse and clears the timer. FINISH (ST_RUN to ST_IDLE) happens on a done pulse. EXPIRE_RELOAD (ST_RUN to ST_RUN) happens on expiry without freeze and reloads the timer. EXPIRE_HOLD (ST_RUN to ST_FROZEN) happens on expiry with freeze. RELEASE (ST_FROZEN to ST_IDLE) happens on a clear strobe or a done pulse. DISABLE (any state to ST_IDLE) happens when the port's enable bit is low.

A start pulse has priority over a done pulse in the same cycle, and a done pulse has priority over expiry.

Top module: `jobdog_top`

## Requirements
- R1: Bit 2p of `wd_mode` enables port p. While it is 0 the port stays idle, never raises its request, and dropping it abandons a job being timed.
- R2: A port with limit L > 0 (field p of `wd_limit`, bits 16p+15..16p) sets its request at the clock edge that samples the 16·L-th tick counted after the job-start edge, and not earlier. A limit of 0 never expires.
- R3: Request bit p is set only by an expiry of port p. Software cannot set it.
- R4: `irq` is 1 exactly when, for some p, `req_pending[p]` and `irq_enable[p]` are both 1. A change of `irq_enable` takes effect at once.
- R5: A done pulse before expiry stops the timer, and no request follows.
- R6: A start pulse on a port that is already timing restarts the timing from zero.
- R7: `done_count` increases by the number of `job_done` bits set in each cycle, whatever the port states are. It wraps modulo 2^32.
- R8: With bit 2p+1 of `wd_mode` at 0 (no freeze), the timer reloads on expiry and expires again every 16·L ticks until the job ends.
- R9: With bit 2p+1 of `wd_mode` at 1 (freeze), the timer stops at expiry. After the request is cleared, no further expiry occurs until a new start pulse.
- R10: A 1 on `req_clear[p]` clears request bit p at the next edge. An expiry of port p in the same cycle wins, and the bit stays set.
- R11: After reset all request bits, `irq` and `done_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| wd_mode | input | 2*NUM_PORTS | Per port: bit 2p enable, bit 2p+1 freeze on expiry |
| wd_limit | input | 16*NUM_PORTS | Per-port timeout in units of 16 ticks |
| job_start | input | NUM_PORTS | Job issued pulse per port |
| job_done | input | NUM_PORTS | Job finished pulse per port |
| irq_enable | input | NUM_PORTS | Interrupt enable per request bit |
| req_clear | input | NUM_PORTS | Write-one-to-clear strobe per request bit |
| req_pending | output | NUM_PORTS | Request bits, one per port |
| irq | output | 1 | OR of enabled requests |
| done_count | output | 32 | Total completed jobs |

## Verification
The bench builds the block with two ports, the prescale of 16 and a 16-bit limit. It drives a tick every cycle, so limits of 1 and 2 bring an expiry within 16 and 32 ticks. At that scale the exact expiry edge, the one-tick-early point, the reload period and the collision of a clear strobe with a second expiry can all be hit on a chosen cycle. With two ports it can also show that one port's freeze setting and request leave the other untouched, and that simultaneous done pulses add two to the count.

// File: rtl/jobdog_pkg.sv
package jobdog_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FROZEN = 2'd2
    } wd_state_e;
endpackage

// File: rtl/jobdog_timer.sv
module jobdog_timer
    import jobdog_pkg::*;
#(
    parameter int PRESCALE = 16,
    parameter int LIMIT_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ms_tick,
    input  logic               run_en,
    input  logic               freeze_en,
    input  logic [LIMIT_W-1:0] limit,
    input  logic               job_start,
    input  logic               job_done,
    input  logic               req_clear,
    output logic               expire_o
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    wd_state_e          state_q, state_d;
    logic [PRE_W-1:0]   pre_q;
    logic [LIMIT_W-1:0] units_q;
    logic               unit_done, hit;

    assign unit_done = ms_tick && (pre_q == PRE_LAST);
    assign hit       = (state_q == ST_RUN) && unit_done && (limit != '0)
                       && (units_q == limit - 1'b1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (run_en && job_start) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!run_en)              state_d = ST_IDLE;
                else if (job_start)       state_d = ST_RUN;
                else if (job_done)        state_d = ST_IDLE;
                else if (hit && freeze_en) state_d = ST_FROZEN;
            end
            ST_FROZEN: begin
                if (!run_en)                     state_d = ST_IDLE;
                else if (job_start)              state_d = ST_RUN;
                else if (job_done || req_clear)  state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        expire_o = hit && run_en && !job_start && !job_done;
    end

    // prescaler and unit timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q   <= '0;
            units_q <= '0;
        end else if (state_q == ST_IDLE || job_start) begin
            pre_q   <= '0;
            units_q <= '0;
        end else if (state_q == ST_RUN) begin
            if (!run_en || job_done) begin
                pre_q   <= '0;
                units_q <= '0;
            end else if (ms_tick) begin
                if (unit_done) begin
                    pre_q   <= '0;
                    units_q <= (hit && !freeze_en) ? '0 : units_q + 1'b1;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end
        end
    end

    // R1: a disabled port is idle on the next edge
    assert_disable_idles_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> state_q == ST_IDLE);

    // R9: a frozen timer holds while nothing releases it
    assert_frozen_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FROZEN && run_en && !job_start && !job_done && !req_clear)
        |=> state_q == ST_FROZEN);

    // R8: after an expiry the port is still timing or frozen
    assert_expiry_keeps_job_R8: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> state_q != ST_IDLE);
endmodule

// File: rtl/jobdog_irq.sv
module jobdog_irq #(
    parameter int NUM_PORTS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] expire,
    input  logic [NUM_PORTS-1:0] req_clear,
    input  logic [NUM_PORTS-1:0] irq_enable,
    output logic [NUM_PORTS-1:0] req_o,
    output logic                 irq_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_o <= '0;
        else        req_o <= expire | (req_o & ~req_clear);
    end

    assign irq_o = |(req_o & irq_enable);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        // R10: expiry always leaves the bit set, even against a clear
        assert_expiry_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
            expire[p] |=> req_o[p]);
        // R3: without expiry a clear bit stays clear
        assert_only_expiry_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!req_o[p] && !expire[p]) |=> !req_o[p]);
    end
endmodule

// File: rtl/jobdog_done_cnt.sv
module jobdog_done_cnt #(
    parameter int NUM_PORTS = 2,
    parameter int CNT_W     = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] job_done,
    output logic [CNT_W-1:0]     count_o
);
    localparam int ADD_W = $clog2(NUM_PORTS + 1);

    logic [ADD_W-1:0] add;

    always_comb begin
        add = '0;
        for (int i = 0; i < NUM_PORTS; i++) add = add + ADD_W'(job_done[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_o <= '0;
        else        count_o <= count_o + CNT_W'(add);
    end

    // R7: any done pulse moves the count, none leaves it alone
    assert_count_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (job_done != '0) |=> count_o != $past(count_o));
    assert_count_still_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (job_done == '0) |=> $stable(count_o));
endmodule

// File: rtl/jobdog_top.sv
module jobdog_top #(
    parameter int NUM_PORTS = 2,
    parameter int PRESCALE  = 16,
    parameter int LIMIT_W   = 16,
    parameter int CNT_W     = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ms_tick,
    input  logic [2*NUM_PORTS-1:0]       wd_mode,
    input  logic [LIMIT_W*NUM_PORTS-1:0] wd_limit,
    input  logic [NUM_PORTS-1:0]         job_start,
    input  logic [NUM_PORTS-1:0]         job_done,
    input  logic [NUM_PORTS-1:0]         irq_enable,
    input  logic [NUM_PORTS-1:0]         req_clear,
    output logic [NUM_PORTS-1:0]         req_pending,
    output logic                         irq,
    output logic [CNT_W-1:0]             done_count
);
    logic [NUM_PORTS-1:0] expire;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        jobdog_timer #(
            .PRESCALE (PRESCALE),
            .LIMIT_W  (LIMIT_W)
        ) u_timer (
            .clk       (clk),
            .rst_n     (rst_n),
            .ms_tick   (ms_tick),
            .run_en    (wd_mode[2*p]),
            .freeze_en (wd_mode[2*p+1]),
            .limit     (wd_limit[p*LIMIT_W +: LIMIT_W]),
            .job_start (job_start[p]),
            .job_done  (job_done[p]),
            .req_clear (req_clear[p]),
            .expire_o  (expire[p])
        );
    end

    jobdog_irq #(.NUM_PORTS(NUM_PORTS)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire     (expire),
        .req_clear  (req_clear),
        .irq_enable (irq_enable),
        .req_o      (req_pending),
        .irq_o      (irq)
    );

    jobdog_done_cnt #(.NUM_PORTS(NUM_PORTS), .CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .job_done (job_done),
        .count_o  (done_count)
    );

    // R4: the interrupt line needs a pending request behind it
    assert_irq_has_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (req_pending != '0));
endmodule

// File: tb/jobdog_top_tb.sv
`timescale 1ns/1ps
module jobdog_top_tb;
    localparam int P = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ms_tick = 1'b0;
    logic [3:0]    wd_mode = '0;
    logic [31:0]   wd_limit = '0;
    logic [1:0]    job_start = '0, job_done = '0, irq_enable = '0, req_clear = '0;
    logic [1:0]    req_pending;
    logic          irq;
    logic [31:0]   done_count;

    int n_chk = 0, n_bad = 0;
    int unsigned exp_cnt = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    jobdog_top #(.NUM_PORTS(P), .PRESCALE(16), .LIMIT_W(16), .CNT_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .wd_mode(wd_mode),
        .wd_limit(wd_limit), .job_start(job_start), .job_done(job_done),
        .irq_enable(irq_enable), .req_clear(req_clear),
        .req_pending(req_pending), .irq(irq), .done_count(done_count));

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // one clock cycle with the given inputs; entered and left at a falling edge
    task automatic cyc(input logic tk, input logic [1:0] st, input logic [1:0] dn,
                       input logic [1:0] cl);
        ms_tick = tk; job_start = st; job_done = dn; req_clear = cl;
        exp_cnt += $countones(dn);
        @(negedge clk);
        ms_tick = 0; job_start = '0; job_done = '0; req_clear = '0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 2'b00, 2'b00, 2'b00);
    endtask

    task automatic tidy();
        cyc(1'b0, 2'b00, 2'b11, 2'b11);
        cyc(1'b0, 2'b00, 2'b00, 2'b11);
    endtask

    task automatic t_reset();
        chk("R11 req after reset", 32'(req_pending), 0);
        chk("R11 irq after reset", 32'(irq), 0);
        chk("R11 count after reset", done_count, 0);
    endtask

    task automatic t_exact_expiry();
        wd_mode = 4'b0001; wd_limit = {16'd0, 16'd2};
        cyc(1'b0, 2'b01, 2'b00, 2'b00);
        ticks(31);
        chk("R2 no request one tick early", 32'(req_pending), 0);
        ticks(1);
        chk("R2 request at 32nd tick", 32'(req_pending), 1);
        tidy();
        chk("R10 clear drops request", 32'(req_pending), 0);
    endtask

    task automatic t_limit_zero();
        wd_mode = 4'b0001; wd_limit = '0;
        cyc(1'b0, 2'b01, 2'b00, 2'b00);
        ticks(40);
        chk("R2 zero limit never expires", 32'(req_pending), 0);
        tidy();
    endtask

    task automatic t_disabled();
        wd_mode = 4'b0000; wd_limit = {16'd1, 16'd1};
        cyc(1'b0, 2'b11, 2'b00, 2'b00);
        ticks(40);
        chk("R1 disabled port no request", 32'(req_pending), 0);
        wd_mode = 4'b0001;
        cyc(1'b0, 2'b01, 2'b00, 2'b00);
        ticks(10);
        wd_mode = 4'b0000;
        ticks(1);
        wd_mode = 4'b0001;
        ticks(30);
        chk("R1 dropped enable abandons job", 32'(req_pending), 0);
        tidy();
    endtask

    task automatic t_done_early();
        wd_mode = 4'b0001; wd_limit = {16'd0, 16'd2};
        cyc(1'b0, 2'b01, 2'b00, 2'b00);
        ticks(31);
        cyc(1'b0, 2'b00, 2'b01, 2'b00);
        ticks(40);
        chk("R5 done before expiry", 32'(req_pending), 0);
        tidy();
    endtask

    task automatic t_restart();
        wd_mode = 4'b0001; wd_limit = {16'd0, 16'd2};
        cyc(1'b0, 2'b01, 2'b00, 2'b00);
        ticks(20);
        cyc(1'b0, 2'b01, 2'b00, 2'b00);
        ticks(31);
        chk("R6 restart resets timing", 32'(req_pending), 0);
        ticks(1);
        chk("R6 expiry 32 ticks after restart", 32'(req_pending), 1);
        tidy();
    endtask

    task automatic t_reload_and_collision();
        wd_mode = 4'b0001; wd_limit = {16'd0, 16'd1};
        cyc(1'b0, 2'b01, 2'b00, 2'b00);
        ticks(16);
        chk("R8 first expiry", 32'(req_pending), 1);
        cyc(1'b0, 2'b00, 2'b00, 2'b01);
        chk("R10 clear alone", 32'(req_pending), 0);
        ticks(15);
        chk("R8 no early second expiry", 32'(req_pending), 0);
        ticks(1);
        chk("R8 reload expires again", 32'(req_pending), 1);
        ticks(15);
        cyc(1'b1, 2'b00, 2'b00, 2'b01);
        chk("R10 expiry beats clear", 32'(req_pending), 1);
        tidy();
    endtask

    task automatic t_freeze();
        wd_mode = 4'b1100; wd_limit = {16'd1, 16'd0};
        cyc(1'b0, 2'b10, 2'b00, 2'b00);
        ticks(16);
        chk("R9 frozen port expiry", 32'(req_pending), 2);
        cyc(1'b0, 2'b00, 2'b00, 2'b10);
        ticks(40);
        chk("R9 no expiry after clear", 32'(req_pending), 0);
        cyc(1'b0, 2'b10, 2'b00, 2'b00);
        ticks(16);
        chk("R9 new job times again", 32'(req_pending), 2);
        tidy();
    endtask

    task automatic t_irq_mask();
        wd_mode = 4'b0001; wd_limit = {16'd0, 16'd1};
        irq_enable = 2'b00;
        cyc(1'b0, 2'b01, 2'b00, 2'b00);
        ticks(16);
        chk("R3 only expired port requests", 32'(req_pending), 1);
        chk("R4 masked irq", 32'(irq), 0);
        irq_enable = 2'b10; #1;
        chk("R4 other port enable", 32'(irq), 0);
        irq_enable = 2'b01; #1;
        chk("R4 enabled irq", 32'(irq), 1);
        irq_enable = 2'b00; #1;
        chk("R4 runtime mask", 32'(irq), 0);
        irq_enable = 2'b11;
        tidy();
        #1;
        chk("R4 irq follows clear", 32'(irq), 0);
        irq_enable = 2'b00;
    endtask

    task automatic t_count();
        wd_mode = 4'b0101;
        cyc(1'b0, 2'b00, 2'b11, 2'b00);
        chk("R7 two dones at once", done_count, exp_cnt);
        cyc(1'b0, 2'b00, 2'b10, 2'b00);
        cyc(1'b0, 2'b00, 2'b00, 2'b00);
        chk("R7 idle done counts", done_count, exp_cnt);
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_exact_expiry();
        t_limit_zero();
        t_disabled();
        t_done_early();
        t_restart();
        t_reload_and_collision();
        t_freeze();
        t_irq_mask();
        t_count();
        chk("R7 running total", done_count, exp_cnt);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule